// File: doc/BRIEF.md
# Frame Sync Time Stamp Stamper and Regenerator

This block carries a video frame synchronisation event across an isochronous bus. It does so with a 16-bit SYT time stamp. On the sending side, a rising edge on the asynchronous frame-sync input is synchronised into the cycle-timer clock domain. The edge is then stamped with the bus cycle timer projected three bus cycles ahead. The result is held on `tx_syt_o`, where the header builder picks it up. Once the bus reaches the stamped cycle, the stamp is withdrawn and the no-information code 0xFFFF is shown again.

On the receiving side, a SYT value taken from an incoming header is loaded with a strobe and armed. When the local cycle timer reaches that value, the block emits a single one-clock pulse on `fsync_o` and disarms. All of this runs on the cycle-timer clock and never on the AV data clock. Both directions are active only while the stream format selects DV video.

Top module: `fsync_syt_unit`

## Requirements
- R1: After reset, `tx_syt_o` is 0xFFFF and `fsync_o` is 0.
- R2: A rising edge of `fsync_i` is sampled by a two-flop synchroniser. `tx_syt_o` then becomes `{nib, ofs}`, where `ofs` is `cyc_offset_i` in bits [11:0] and `nib` is the low four bits of `(cyc_count_i + 3) mod 8000` in bits [15:12]. Both are taken at the clock edge three edges after `fsync_i` is first sampled high.
- R3: The three-cycle projection wraps correctly. Cycle count 14 gives nibble 1, and cycle count 7999 gives nibble 2. The offset 3071 is carried unchanged.
- R4: A frame-sync input held high for many clocks produces exactly one stamp. Timer changes while it stays high do not restamp.
- R5: A new rising edge while a stamp is pending replaces the pending stamp.
- R6: A pending stamp is withdrawn (`tx_syt_o` returns to 0xFFFF) one edge after `cyc_count_i[3:0]` equals `tx_syt_o[15:12]`.
- R7: While `dv_en_i` is low, `tx_syt_o` is 0xFFFF from the next edge on, any pending stamp is dropped, and `fsync_i` edges are ignored.
- R8: When an armed SYT equals `{cyc_count_i[3:0], cyc_offset_i}` at a clock edge, `fsync_o` is high for exactly the following clock cycle.
- R9: A loaded SYT fires at most once. A new load re-arms the comparator.
- R10: A load of 0xFFFF never arms the comparator and disarms any earlier value. A load while `dv_en_i` is low is ignored. Lowering `dv_en_i` disarms the comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cycle-timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dv_en_i | input | 1 | Stream format is DV video; enables the block |
| cyc_count_i | input | 13 | Bus cycle count, 0..7999 |
| cyc_offset_i | input | 12 | Cycle offset, 0..3071 |
| fsync_i | input | 1 | Asynchronous frame-sync input |
| rx_syt_i | input | 16 | SYT value from a received header |
| rx_syt_load_i | input | 1 | Load strobe for `rx_syt_i` |
| tx_syt_o | output | 16 | SYT for the header being built, 0xFFFF if none |
| fsync_o | output | 1 | Regenerated frame-sync pulse |

## Verification
The stamper is driven at an ordinary mid-range cycle count, at cycle count 14 with the largest offset, and at count 7999. These three cases separate a plain modulo-16 add from a wrong wrap at the cycle-count limit, and show whether the offset is dropped. Two short pulses in close succession and one long held pulse distinguish replacement of a pending stamp from level-sensitive restamping. The regenerator is held at a matching timer for several clocks, then revisited at the same nibble and offset without a reload, to tell a one-shot from a repeating compare. It is also loaded with 0xFFFF, loaded while disabled, and disabled after arming, to show that none of these paths leaves the comparator armed.

// File: rtl/fsync_syt_pkg.sv
package fsync_syt_pkg;
  localparam int unsigned CNT_W   = 13;
  localparam int unsigned OFS_W   = 12;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned SYT_W   = NIB_W + OFS_W;
  localparam int unsigned CNT_MOD = 8000;
  localparam int unsigned OFS_MAX = 3071;
  localparam logic [SYT_W-1:0] SYT_NONE = '1;

  typedef struct packed {
    logic [NIB_W-1:0] nib;
    logic [OFS_W-1:0] ofs;
  } syt_t;
endpackage

// File: rtl/fsync_edge_sync.sv
module fsync_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/syt_stamper.sv
module syt_stamper
  import fsync_syt_pkg::*;
#(
  parameter int unsigned LEAD = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cyc_count_i,
  input  logic [OFS_W-1:0] cyc_offset_i,
  output logic [SYT_W-1:0] syt_o
);
  localparam int unsigned SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] fut;
  syt_t             syt_q;
  logic             pending;

  // projected cycle, wrapped at the cycle-count limit
  always_comb begin
    sum = SUM_W'(cyc_count_i) + SUM_W'(LEAD);
    fut = (sum >= SUM_W'(CNT_MOD)) ? sum - SUM_W'(CNT_MOD) : sum;
  end

  assign pending = (syt_q != SYT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      syt_q <= SYT_NONE;
    end else if (!en_i) begin
      syt_q <= SYT_NONE;
    end else if (rise_i) begin
      syt_q.nib <= fut[NIB_W-1:0];
      syt_q.ofs <= cyc_offset_i;
    end else if (pending && syt_q.nib == cyc_count_i[NIB_W-1:0]) begin
      syt_q <= SYT_NONE;
    end
  end

  assign syt_o = syt_q;
endmodule

// File: rtl/syt_regen.sv
module syt_regen
  import fsync_syt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [SYT_W-1:0] syt_i,
  input  logic [NIB_W-1:0] cyc_nib_i,
  input  logic [OFS_W-1:0] cyc_offset_i,
  output logic             pulse_o
);
  syt_t tgt_q;
  logic armed_q;
  logic pulse_q;
  logic match;

  assign match = en_i && armed_q && tgt_q.nib == cyc_nib_i && tgt_q.ofs == cyc_offset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q   <= SYT_NONE;
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= match;
      if (!en_i) begin
        armed_q <= 1'b0;
      end else if (load_i) begin
        armed_q <= (syt_i != SYT_NONE);
        tgt_q   <= syt_i;
      end else if (match) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/fsync_syt_unit.sv
module fsync_syt_unit
  import fsync_syt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEAD        = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dv_en_i,
  input  logic [CNT_W-1:0] cyc_count_i,
  input  logic [OFS_W-1:0] cyc_offset_i,
  input  logic             fsync_i,
  input  logic [SYT_W-1:0] rx_syt_i,
  input  logic             rx_syt_load_i,
  output logic [SYT_W-1:0] tx_syt_o,
  output logic             fsync_o
);
  logic rise;

  fsync_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(fsync_i),
    .rise_o (rise)
  );

  syt_stamper #(.LEAD(LEAD)) i_stamp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (dv_en_i),
    .rise_i      (rise),
    .cyc_count_i (cyc_count_i),
    .cyc_offset_i(cyc_offset_i),
    .syt_o       (tx_syt_o)
  );

  syt_regen i_regen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (dv_en_i),
    .load_i      (rx_syt_load_i),
    .syt_i       (rx_syt_i),
    .cyc_nib_i   (cyc_count_i[NIB_W-1:0]),
    .cyc_offset_i(cyc_offset_i),
    .pulse_o     (fsync_o)
  );
endmodule

// File: rtl/fsync_syt_chk.sv
module fsync_syt_chk
  import fsync_syt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dv_en_i,
  input logic [SYT_W-1:0] tx_syt_o,
  input logic             fsync_o
);
  // R7
  tx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dv_en_i |=> tx_syt_o == SYT_NONE);

  // R10
  rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dv_en_i |=> !fsync_o);

  // R8
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |=> !fsync_o);

  // R2
  stamp_ofs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_syt_o != SYT_NONE |-> tx_syt_o[OFS_W-1:0] <= OFS_W'(OFS_MAX));
endmodule

bind fsync_syt_unit fsync_syt_chk i_fsync_syt_chk (.*);

// File: tb/test_fsync_syt_unit.sv
`timescale 1ns/1ps
module test_fsync_syt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dv_en = 1'b0;
  logic [12:0] cnt = '0;
  logic [11:0] ofs = '0;
  logic        fsync = 1'b0;
  logic [15:0] rx_syt = '0;
  logic        rx_load = 1'b0;
  logic [15:0] tx_syt;
  logic        fsync_out;

  int n_chk = 0;
  int n_fail = 0;
  int n_pulse = 0;
  bit done = 1'b0;

  logic [15:0] exp_tx_q[$];
  string       tag_tx_q[$];
  logic [15:0] exp_pl_q[$];

  always #2 clk = ~clk;

  fsync_syt_unit i_fsync_syt_unit (
    .clk_i(clk), .rst_ni(rst_n), .dv_en_i(dv_en), .cyc_count_i(cnt),
    .cyc_offset_i(ofs), .fsync_i(fsync), .rx_syt_i(rx_syt),
    .rx_syt_load_i(rx_load), .tx_syt_o(tx_syt), .fsync_o(fsync_out)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_timer(input int c, input int o);
    @(negedge clk);
    cnt = 13'(c);
    ofs = 12'(o);
  endtask

  task automatic push_tx(input logic [15:0] v, input string tag);
    exp_tx_q.push_back(v);
    tag_tx_q.push_back(tag);
  endtask

  task automatic pulse_in();
    @(negedge clk); fsync = 1'b1;
    @(negedge clk); fsync = 1'b0;
  endtask

  task automatic load_rx(input logic [15:0] v);
    @(negedge clk); rx_syt = v; rx_load = 1'b1;
    @(negedge clk); rx_load = 1'b0;
  endtask

  // monitor: pops expected items as outputs change
  initial begin
    logic [15:0] prev_tx;
    logic        prev_pl;
    prev_tx = 16'hFFFF;
    prev_pl = 1'b0;
    @(posedge rst_n);
    forever begin
      @(posedge clk); #1;
      if (tx_syt !== prev_tx) begin
        if (exp_tx_q.size() == 0) chk(tx_syt, prev_tx, "R2 unexpected tx change");
        else chk(tx_syt, exp_tx_q.pop_front(), tag_tx_q.pop_front());
        prev_tx = tx_syt;
      end
      if (fsync_out) begin
        n_pulse++;
        // R8 width, R9 once
        if (prev_pl) chk(16'd1, 16'd0, "R8 pulse wider than one clock");
        else if (exp_pl_q.size() == 0) chk(16'd1, 16'd0, "R9 unexpected pulse");
        else chk({cnt[3:0], ofs}, exp_pl_q.pop_front(), "R8 pulse timing");
      end
      prev_pl = fsync_out;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    chk(tx_syt, 16'hFFFF, "R1 tx after reset");
    chk({15'd0, fsync_out}, 16'd0, "R1 pulse after reset");

    dv_en = 1'b1;
    // R2 mid-range
    set_timer(5, 100); push_tx(16'h8064, "R2 stamp 5/100");
    pulse_in(); cycles(5);
    push_tx(16'hFFFF, "R6 clear"); set_timer(8, 0); cycles(3);

    // R3 offset max, nibble wrap; R4 long pulse
    set_timer(14, 3071); push_tx(16'h1BFF, "R3 stamp 14/3071");
    @(negedge clk); fsync = 1'b1; cycles(5);
    set_timer(15, 100); cycles(5);
    @(negedge clk); fsync = 1'b0; cycles(3);
    push_tx(16'hFFFF, "R6 clear"); set_timer(17, 5); cycles(3);

    // R3 cycle-count limit
    set_timer(7999, 0); push_tx(16'h2000, "R3 stamp 7999/0");
    pulse_in(); cycles(5);
    push_tx(16'hFFFF, "R6 clear"); set_timer(2, 9); cycles(3);

    // R5 replacement
    set_timer(20, 50); push_tx(16'h7032, "R5 first stamp");
    pulse_in(); cycles(5);
    set_timer(21, 60); push_tx(16'h803C, "R5 replacing stamp");
    pulse_in(); cycles(5);
    push_tx(16'hFFFF, "R6 clear"); set_timer(24, 0); cycles(3);

    // R7 disable drops pending, ignores edges
    set_timer(40, 10); push_tx(16'hB00A, "R7 stamp before disable");
    pulse_in(); cycles(5);
    push_tx(16'hFFFF, "R7 drop on disable");
    @(negedge clk); dv_en = 1'b0; cycles(3);
    set_timer(30, 0); pulse_in(); cycles(6);
    chk(tx_syt, 16'hFFFF, "R7 no stamp while disabled");

    // R8/R9 receive one-shot
    dv_en = 1'b1;
    set_timer(0, 0); load_rx(16'h3123);
    exp_pl_q.push_back(16'h3123);
    set_timer(35, 291); cycles(4);
    set_timer(36, 0); cycles(2);
    set_timer(51, 291); cycles(4);

    // R10 disable disarms
    set_timer(0, 0); load_rx(16'h6002);
    @(negedge clk); dv_en = 1'b0; cycles(2);
    @(negedge clk); dv_en = 1'b1;
    set_timer(6, 2); cycles(4);

    // R9 reload re-arms
    set_timer(0, 0); load_rx(16'h6002);
    exp_pl_q.push_back(16'h6002);
    set_timer(22, 2); cycles(4);

    // R10 load while disabled ignored
    set_timer(0, 0);
    @(negedge clk); dv_en = 1'b0;
    load_rx(16'h5001);
    @(negedge clk); dv_en = 1'b1;
    set_timer(5, 1); cycles(4);

    // R10 0xFFFF load disarms
    set_timer(0, 0); load_rx(16'h7010); load_rx(16'hFFFF);
    set_timer(7, 16); cycles(4);
    set_timer(0, 0); cycles(4);

    chk(16'(exp_tx_q.size()), 16'd0, "R2 expected stamps seen");
    chk(16'(exp_pl_q.size()), 16'd0, "R9 expected pulses seen");
    chk(16'(n_pulse), 16'd2, "R10 total pulse count");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule